// File: doc/BRIEF.md
# Strobe-Driven Accumulator Micro-Operation Unit

This block is a register-level datapath slice holding an accumulator `accA`, an operand register `regB` and a one-bit carry extension `carryE`. On each clock edge it applies at most one micro-operation to the accumulator: clear, complement, XOR or AND with the operand, add the operand with the carry out captured in the extension bit, logical shift left or right, rotate left or right, or a parallel copy of the operand into the accumulator. Each operation has its own one-bit strobe.

The operand register loads in parallel from a data input whenever its load enable is high. The load is independent of the accumulator strobes. When two or more accumulator strobes are high in the same cycle, the accumulator and carry keep their values and a sticky error flag is set. Only reset clears that flag.

Top module: `microop_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator, the operand register, the carry bit and the error flag to zero.
- R2: With no strobe asserted, the accumulator and the carry bit hold their values.
- R3: The add strobe writes the low WIDTH bits of A + B into A and writes the carry-out into E in the same edge.
- R4: The clear strobe loads zero, the complement strobe loads ~A, the XOR strobe loads A ^ B, and the AND strobe loads A & B. E is unchanged.
- R5: Shift left loads {A[WIDTH-2:0],0} and shift right loads {0,A[WIDTH-1:1]}. E is unchanged.
- R6: Rotate left loads {A[WIDTH-2:0],A[WIDTH-1]} and rotate right loads {A[0],A[WIDTH-1:1]}. E is unchanged.
- R7: The transfer strobe copies B into A in one clock, and E is unchanged.
- R8: When `loadB` is high, B takes `dataIn` at the edge. This is independent of the accumulator strobes, and an operation in the same cycle uses the old B.
- R9: If two or more accumulator strobes are high at an edge, A and E hold their values and `strobeErr` goes high one cycle later and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opClr | input | 1 | Clear accumulator strobe |
| opCom | input | 1 | Complement accumulator strobe |
| opXor | input | 1 | XOR with operand strobe |
| opAnd | input | 1 | AND with operand strobe |
| opAdd | input | 1 | Add operand, carry into E |
| opShl | input | 1 | Logical shift left strobe |
| opShr | input | 1 | Logical shift right strobe |
| opRol | input | 1 | Rotate left strobe |
| opRor | input | 1 | Rotate right strobe |
| opXfer | input | 1 | Copy operand into accumulator |
| loadB | input | 1 | Operand register load enable |
| dataIn | input | WIDTH | Operand load data |
| accA | output | WIDTH | Accumulator value |
| carryE | output | 1 | Carry extension bit |
| strobeErr | output | 1 | Sticky multiple-strobe error |

## Verification
Two kinds of activity can land on the same edge. An operand load can coincide with an accumulator operation that reads the operand, and two accumulator strobes can collide. The bench drives loads together with XOR, AND, add and transfer strobes and checks that the result uses the old operand. It also raises random pairs of strobes and checks that A and E keep their values and that the error flag rises and then stays set through later legal operations.

// File: rtl/microop_pkg.sv
package microop_pkg;
  localparam int NUM_OPS = 10;

  typedef struct packed {
    logic clr;
    logic com;
    logic xorB;
    logic andB;
    logic add;
    logic shl;
    logic shr;
    logic rol;
    logic ror;
    logic xfer;
  } opStrobes_t;
endpackage

// File: rtl/microop_ctrl.sv
module microop_ctrl
  import microop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  opStrobes_t rawOps,
  output opStrobes_t execOps,
  output logic       strobeErr
);
  logic [NUM_OPS-1:0] opVec;
  logic               collide;
  logic               errQ;

  assign opVec   = rawOps;
  assign collide = ($countones(opVec) > 1);
  assign execOps = collide ? '0 : rawOps;

  always_ff @(posedge clk) begin
    if (rst) errQ <= 1'b0;
    else if (collide) errQ <= 1'b1;
  end

  assign strobeErr = errQ;

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    errQ |=> errQ);
  assert_err_sets_R9: assert property (@(posedge clk) disable iff (rst)
    collide |=> errQ);
  assert_exec_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(execOps));
endmodule

// File: rtl/microop_datapath.sv
module microop_datapath
  import microop_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  opStrobes_t       ops,
  input  logic             loadB,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] accA,
  output logic             carryE
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] aQ, bQ, aNext;
  logic             eQ, eNext;
  logic [WIDTH:0]   sumExt;

  assign sumExt = {1'b0, aQ} + {1'b0, bQ};

  always_comb begin
    aNext = aQ;
    eNext = eQ;
    unique case (1'b1)
      ops.clr:  aNext = '0;
      ops.com:  aNext = ~aQ;
      ops.xorB: aNext = aQ ^ bQ;
      ops.andB: aNext = aQ & bQ;
      ops.add: begin
        aNext = sumExt[MSB:0];
        eNext = sumExt[WIDTH];
      end
      ops.shl:  aNext = {aQ[MSB-1:0], 1'b0};
      ops.shr:  aNext = {1'b0, aQ[MSB:1]};
      ops.rol:  aNext = {aQ[MSB-1:0], aQ[MSB]};
      ops.ror:  aNext = {aQ[0], aQ[MSB:1]};
      ops.xfer: aNext = bQ;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aQ <= '0;
      bQ <= '0;
      eQ <= 1'b0;
    end else begin
      aQ <= aNext;
      eQ <= eNext;
      if (loadB) bQ <= dataIn;
    end
  end

  assign accA   = aQ;
  assign carryE = eQ;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ops == '0) |=> $stable(aQ) && $stable(eQ));
  assert_carry_only_add_R3: assert property (@(posedge clk) disable iff (rst)
    !ops.add |=> $stable(eQ));
  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ops.clr |=> (aQ == '0));
  assert_xfer_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (ops.xfer && !loadB) |=> (aQ == bQ));
  assert_rotate_ones_R6: assert property (@(posedge clk) disable iff (rst)
    (ops.rol || ops.ror) |=> ($countones(aQ) == $countones($past(aQ))));
endmodule

// File: rtl/microop_unit.sv
module microop_unit
  import microop_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             opClr,
  input  logic             opCom,
  input  logic             opXor,
  input  logic             opAnd,
  input  logic             opAdd,
  input  logic             opShl,
  input  logic             opShr,
  input  logic             opRol,
  input  logic             opRor,
  input  logic             opXfer,
  input  logic             loadB,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] accA,
  output logic             carryE,
  output logic             strobeErr
);
  opStrobes_t rawOps, execOps;

  assign rawOps = '{clr: opClr, com: opCom, xorB: opXor, andB: opAnd,
                    add: opAdd, shl: opShl, shr: opShr, rol: opRol,
                    ror: opRor, xfer: opXfer};

  microop_ctrl ctrl_i (
    .clk(clk), .rst(rst), .rawOps(rawOps), .execOps(execOps),
    .strobeErr(strobeErr)
  );

  microop_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rst(rst), .ops(execOps), .loadB(loadB), .dataIn(dataIn),
    .accA(accA), .carryE(carryE)
  );
endmodule

// File: tb/microop_unit_tb.sv
module microop_unit_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst;
  logic [9:0] ops;
  logic loadB;
  logic [W-1:0] dataIn;
  logic [W-1:0] accA;
  logic carryE, strobeErr;
  int checks = 0;
  int fails = 0;
  logic [W-1:0] mA, mB;
  logic mE, mErr;

  always #4 clk = ~clk;

  // ops index: 0 clr,1 com,2 xor,3 and,4 add,5 shl,6 shr,7 rol,8 ror,9 xfer
  microop_unit #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst),
    .opClr(ops[0]), .opCom(ops[1]), .opXor(ops[2]), .opAnd(ops[3]),
    .opAdd(ops[4]), .opShl(ops[5]), .opShr(ops[6]), .opRol(ops[7]),
    .opRor(ops[8]), .opXfer(ops[9]),
    .loadB(loadB), .dataIn(dataIn),
    .accA(accA), .carryE(carryE), .strobeErr(strobeErr)
  );

  function automatic logic [W:0] modelOp(int idx, logic [W-1:0] a,
                                         logic [W-1:0] b, logic e);
    logic [W:0] s;
    case (idx)
      0: return {e, {W{1'b0}}};
      1: return {e, ~a};
      2: return {e, a ^ b};
      3: return {e, a & b};
      4: begin s = {1'b0, a} + {1'b0, b}; return s; end
      5: return {e, a[W-2:0], 1'b0};
      6: return {e, 1'b0, a[W-1:1]};
      7: return {e, a[W-2:0], a[W-1]};
      8: return {e, a[0], a[W-1:1]};
      9: return {e, b};
      default: return {e, a};
    endcase
  endfunction

  function automatic string reqOf(int idx, int nOps);
    if (nOps > 1) return "R9";
    case (idx)
      4: return "R3";
      0, 1, 2, 3: return "R4";
      5, 6: return "R5";
      7, 8: return "R6";
      9: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] expA, logic expE, logic expErr);
    checks++;
    if (accA !== expA || carryE !== expE || strobeErr !== expErr) begin
      fails++;
      $display("FAIL %s: A=%h E=%b err=%b expected A=%h E=%b err=%b",
               req, accA, carryE, strobeErr, expA, expE, expErr);
    end
  endtask

  // Drive one cycle, update the model, then check after the edge.
  task automatic step(logic [9:0] o, logic ld, logic [W-1:0] d, string tag);
    logic [W:0] r;
    int idx;
    idx = -1;
    for (int i = 0; i < 10; i++) if (o[i]) idx = i;
    ops = o; loadB = ld; dataIn = d;
    @(posedge clk);
    #1;
    if ($countones(o) > 1) mErr = 1'b1;
    else begin
      r = modelOp(idx, mA, mB, mE);
      mA = r[W-1:0]; mE = r[W];
    end
    if (ld) mB = d;
    check(tag.len() > 0 ? tag : reqOf(idx, $countones(o)), mA, mE, mErr);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: A=%h expected completion", accA);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; ops = '0; loadB = 1'b0; dataIn = '0;
    repeat (2) @(posedge clk);
    #1; rst = 1'b0;
    mA = '0; mB = '0; mE = 1'b0; mErr = 1'b0;
    check("R1", '0, 1'b0, 1'b0);

    // Directed corner cases
    step(10'h000, 1'b1, 16'hFFFF, "R8");
    step(10'h200, 1'b0, 16'h0, "R7");     // A = FFFF
    step(10'h000, 1'b1, 16'h0001, "R8");
    step(10'h010, 1'b0, 16'h0, "R3");     // FFFF+1 -> 0000, E=1
    step(10'h000, 1'b0, 16'h0, "R2");
    step(10'h002, 1'b0, 16'h0, "R4");     // complement -> FFFF, E stays 1
    step(10'h020, 1'b0, 16'h0, "R5");     // shl
    step(10'h040, 1'b0, 16'h0, "R5");     // shr
    step(10'h080, 1'b0, 16'h0, "R6");     // rol
    step(10'h100, 1'b0, 16'h0, "R6");     // ror
    step(10'h200, 1'b1, 16'h1234, "R8");  // xfer uses old B
    step(10'h004, 1'b1, 16'h5555, "R8");  // xor old B with load
    step(10'h001, 1'b0, 16'h0, "R4");

    // Random legal single ops, loads, and idle cycles
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [9:0] o;
      k = $urandom_range(0, 10);
      o = (k == 10) ? 10'h000 : (10'h001 << k);
      step(o, 1'($urandom_range(0, 1)), W'($urandom), "");
    end

    // Collision: two strobes, then confirm hold and stickiness
    step(10'h011, 1'b0, 16'h0, "R9");
    step(10'h180, 1'b1, 16'hA5A5, "R9");
    for (int n = 0; n < 50; n++) begin
      int k;
      k = $urandom_range(0, 9);
      step(10'h001 << k, 1'b0, 16'h0, "");
    end

    rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    mA = '0; mB = '0; mE = 1'b0; mErr = 1'b0;
    check("R1", '0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule